// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 64-bit virtual address into a physical page address for one access (load, store or instruction fetch) made in one of four privilege modes. Before it looks at any table, it checks the address in a fixed order. A physical-access request passes straight through. An address whose upper bits are not a copy of the sign bit faults at once. A negative address that falls in the kernel direct-mapped window is translated with no table reads. Every other address is resolved by reading three levels of 8-byte page table entries through a read port that supports one request at a time.

A request is accepted with a valid/ready handshake, and only one translation is in flight at a time. Each accepted request ends with exactly one single-cycle `done` pulse. That pulse carries either the page address and the granted read/write/execute rights, or a fault code together with the faulting address and an access-type word that a trap handler can use directly. Pages are 8 KiB and 43 virtual address bits are implemented.

Top module: `xlat_walker`

## Requirements
- R1: With `req_phys` high, the result is a success whose page address is `req_vaddr` with its low 13 bits cleared and whose rights are `done_perm` = 3'b111. Bit 0 of `done_perm` is read, bit 1 is write and bit 2 is execute. No table read is made.
- R2: When `req_phys` is low and bits 63:43 of the address are not all equal to bit 63, the result is fault code 1 (access violation) and no table read is made.
- R3: A sign-valid address with bit 63 set and bits 42:41 = 2'b10 that is made in mode 0 (kernel) is a success with rights 3'b111 and no table read. Its page address is bits 39:0 of the address with bit 40 copied to bit 43 and the low 13 bits cleared.
- R4: The same window, accessed in any mode other than 0, gives fault code 1 with no table read.
- R5: Walk reads go in order to root + 8*va[42:33], then L2base + 8*va[32:23], then L3base + 8*va[22:13], with one read request pulse per entry.
- R6: The next table base, and the final page address, are entry bits 63:32 shifted left by 13.
- R7: At the first two levels, entry bit 0 clear gives fault code 0 (not valid). Otherwise, entry bit 8 clear gives fault code 1. Either fault stops the walk.
- R8: At the last level, entry bit 0 clear gives fault code 0.
- R9: For mode m (0..3), read and execute rights come from entry bit 8+m and write comes from bit 12+m. A load needs read, a store needs write and a fetch needs execute. If the needed right is absent, the result is fault code 1.
- R10: Entry bits 1, 2 and 3 then remove read, write and execute respectively. If the needed right is gone, the fault code is 4 for a fetch, 3 for a store and 2 for a load. Otherwise the masked rights are reported.
- R11: Every result reports the request address on `done_vaddr`. It also reports `done_acc` = 0 for a load (`req_acc` 0), 1 for a store (`req_acc` 1) and all ones for a fetch (`req_acc` 2).
- R12: `req_ready` is high only when no translation is in flight, and each accepted request yields exactly one `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vaddr | input | 64 | Virtual address |
| req_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| req_mode | input | 2 | Privilege mode 0..3 (0 kernel) |
| req_phys | input | 1 | Physical-access bypass |
| tbl_root | input | 64 | First-level table base |
| mem_req_valid | output | 1 | Table entry read request pulse |
| mem_req_addr | output | 64 | Table entry address |
| mem_rsp_valid | input | 1 | Entry data valid |
| mem_rsp_data | input | 64 | Entry data |
| done | output | 1 | Result pulse |
| done_fault | output | 1 | Result is a fault |
| done_code | output | 3 | Fault code |
| done_paddr | output | 64 | Physical page address |
| done_perm | output | 3 | Granted rights {X,W,R} |
| done_vaddr | output | 64 | Address of the request |
| done_acc | output | 64 | Access-type word |

## Verification
The assertions assume the memory returns exactly one response for each read pulse and never sends a response while the walker has no read waiting. They also assume `req_acc` never takes the value 3 and `tbl_root` stays constant during a walk. The bench's memory model answers each read a fixed two cycles after the pulse. The driver only issues access codes 0 to 2 and leaves the root unchanged. The stimulus covers each mode, every fault source and the sign and window boundaries.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_e;

    typedef enum logic [2:0] {
        FLT_NOTVALID = 3'd0,
        FLT_ACCVIO   = 3'd1,
        FLT_ON_READ  = 3'd2,
        FLT_ON_WRITE = 3'd3,
        FLT_ON_EXEC  = 3'd4
    } flt_e;

    typedef enum logic [2:0] {
        RT_BYPASS,
        RT_BADVA,
        RT_SP_OK,
        RT_SP_DENY,
        RT_WALK
    } route_e;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_WALK = 1'b1
    } st_e;

    // entry flag bit positions
    localparam int unsigned E_VALID  = 0;
    localparam int unsigned E_NORD   = 1;
    localparam int unsigned E_RD_LSB = 8;
    localparam int unsigned E_WR_LSB = 12;
    localparam int unsigned FLAG_W   = 16;

endpackage

// File: rtl/ptw_front.sv
module ptw_front import ptw_pkg::*; #(
    parameter int unsigned ADDR_W      = 64,
    parameter int unsigned VA_BITS     = 43,
    parameter int unsigned PG_BITS     = 13,
    parameter int unsigned SP_LOW_BITS = 40,
    parameter int unsigned SP_REL_DST  = 43
) (
    input  logic [ADDR_W-1:0] vaddr,
    input  logic [1:0]        mode,
    input  logic              phys,
    output route_e            route,
    output logic [ADDR_W-1:0] sp_page
);
    localparam int unsigned HI_W = ADDR_W - VA_BITS;

    logic sign_ok;
    logic in_window;
    logic [ADDR_W-1:0] sp_raw;

    assign sign_ok   = (vaddr[ADDR_W-1:VA_BITS] == {HI_W{vaddr[ADDR_W-1]}});
    assign in_window = vaddr[ADDR_W-1] && (vaddr[VA_BITS-1 -: 2] == 2'b10);

    always_comb begin
        sp_raw = '0;
        sp_raw[SP_LOW_BITS-1:0] = vaddr[SP_LOW_BITS-1:0];
        sp_raw[SP_REL_DST]      = vaddr[SP_LOW_BITS];
        sp_page = sp_raw;
        sp_page[PG_BITS-1:0] = '0;
    end

    always_comb begin
        if (phys)                route = RT_BYPASS;
        else if (!sign_ok)       route = RT_BADVA;
        else if (in_window)      route = (mode == 2'd0) ? RT_SP_OK : RT_SP_DENY;
        else                     route = RT_WALK;
    end

endmodule

// File: rtl/ptw_dir_check.sv
module ptw_dir_check import ptw_pkg::*; (
    input  logic [FLAG_W-1:0] flags,
    output logic              ok,
    output flt_e              code
);
    always_comb begin
        ok   = 1'b0;
        code = FLT_NOTVALID;
        if (!flags[E_VALID])         code = FLT_NOTVALID;
        else if (!flags[E_RD_LSB])   code = FLT_ACCVIO;
        else                         ok   = 1'b1;
    end
endmodule

// File: rtl/ptw_leaf_eval.sv
module ptw_leaf_eval import ptw_pkg::*; (
    input  logic [FLAG_W-1:0] flags,
    input  logic [1:0]        mode,
    input  acc_e              acc,
    output logic              fault,
    output flt_e              code,
    output logic [2:0]        perm
);
    logic [2:0] need;
    logic [2:0] grant;
    logic [2:0] kept;
    logic       rd_en;
    logic       wr_en;

    always_comb begin
        case (acc)
            ACC_STORE: need = 3'b010;
            ACC_FETCH: need = 3'b100;
            default:   need = 3'b001;
        endcase
        rd_en = flags[E_RD_LSB + 32'(mode)];
        wr_en = flags[E_WR_LSB + 32'(mode)];
        grant = {rd_en, wr_en, rd_en};
        kept  = grant & ~flags[E_NORD +: 3];

        fault = 1'b1;
        code  = FLT_NOTVALID;
        perm  = 3'b000;
        if (!flags[E_VALID]) begin
            code = FLT_NOTVALID;
        end else if ((grant & need) == 3'b000) begin
            code = FLT_ACCVIO;
        end else if ((kept & need) == 3'b000) begin
            if (need[2])      code = FLT_ON_EXEC;
            else if (need[1]) code = FLT_ON_WRITE;
            else              code = FLT_ON_READ;
        end else begin
            fault = 1'b0;
            perm  = kept;
        end
    end
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker import ptw_pkg::*; #(
    parameter int unsigned ADDR_W      = 64,
    parameter int unsigned PTE_W       = 64,
    parameter int unsigned VA_BITS     = 43,
    parameter int unsigned PG_BITS     = 13,
    parameter int unsigned IDX_BITS    = 10,
    parameter int unsigned LEVELS      = 3,
    parameter int unsigned SP_LOW_BITS = 40,
    parameter int unsigned SP_REL_DST  = 43
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic [1:0]        req_acc,
    input  logic [1:0]        req_mode,
    input  logic              req_phys,
    input  logic [ADDR_W-1:0] tbl_root,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [PTE_W-1:0]  mem_rsp_data,
    output logic              done,
    output logic              done_fault,
    output logic [2:0]        done_code,
    output logic [ADDR_W-1:0] done_paddr,
    output logic [2:0]        done_perm,
    output logic [ADDR_W-1:0] done_vaddr,
    output logic [ADDR_W-1:0] done_acc
);
    localparam int unsigned LVL_W     = (LEVELS > 1) ? $clog2(LEVELS) : 1;
    localparam int unsigned SLOTS     = 1 << LVL_W;
    localparam int unsigned ENT_SH    = 3;
    localparam int unsigned PFN_LSB   = 32;
    localparam int unsigned TOP_SHIFT = PG_BITS + IDX_BITS * (LEVELS - 1);

    typedef struct packed {
        st_e               st;
        logic [LVL_W-1:0]  lvl;
        logic [ADDR_W-1:0] va;
        logic [1:0]        mode;
        acc_e              acc;
        logic              rd;
        logic [ADDR_W-1:0] rd_addr;
        logic              fin;
        logic              fault;
        flt_e              code;
        logic [ADDR_W-1:0] paddr;
        logic [2:0]        perm;
    } wk_t;

    wk_t q, d;

    route_e            route;
    logic [ADDR_W-1:0] sp_page;
    logic              dir_ok;
    flt_e              dir_code;
    logic              leaf_fault;
    flt_e              leaf_code;
    logic [2:0]        leaf_perm;
    logic [ADDR_W-1:0] frame;
    logic [IDX_BITS-1:0] idx_lv [SLOTS];
    logic [IDX_BITS-1:0] idx_top;
    logic [LVL_W-1:0]  lvl_nxt;
    logic              at_leaf;
    logic              unused_bits;

    ptw_front #(
        .ADDR_W(ADDR_W), .VA_BITS(VA_BITS), .PG_BITS(PG_BITS),
        .SP_LOW_BITS(SP_LOW_BITS), .SP_REL_DST(SP_REL_DST)
    ) u_front (
        .vaddr(req_vaddr), .mode(req_mode), .phys(req_phys),
        .route(route), .sp_page(sp_page)
    );

    ptw_dir_check u_dir (
        .flags(mem_rsp_data[FLAG_W-1:0]), .ok(dir_ok), .code(dir_code)
    );

    ptw_leaf_eval u_leaf (
        .flags(mem_rsp_data[FLAG_W-1:0]), .mode(q.mode), .acc(q.acc),
        .fault(leaf_fault), .code(leaf_code), .perm(leaf_perm)
    );

    generate
        for (genvar g = 0; g < SLOTS; g++) begin : g_idx
            if (g < LEVELS) begin : g_used
                assign idx_lv[g] = q.va[PG_BITS + IDX_BITS * (LEVELS - 1 - g) +: IDX_BITS];
            end else begin : g_pad
                assign idx_lv[g] = '0;
            end
        end
    endgenerate

    assign idx_top     = req_vaddr[TOP_SHIFT +: IDX_BITS];
    assign frame       = ADDR_W'(mem_rsp_data[PTE_W-1:PFN_LSB]) << PG_BITS;
    assign lvl_nxt     = q.lvl + 1'b1;
    assign at_leaf     = (q.lvl == LVL_W'(LEVELS - 1));
    assign unused_bits = ^mem_rsp_data[PFN_LSB-1:FLAG_W];

    always_comb begin
        d       = q;
        d.rd    = 1'b0;
        d.fin   = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.va    = req_vaddr;
                    d.mode  = req_mode;
                    d.acc   = acc_e'(req_acc);
                    d.fault = 1'b0;
                    d.code  = FLT_NOTVALID;
                    d.paddr = '0;
                    d.perm  = 3'b000;
                    case (route)
                        RT_BYPASS: begin
                            d.fin   = 1'b1;
                            d.paddr = {req_vaddr[ADDR_W-1:PG_BITS], {PG_BITS{1'b0}}};
                            d.perm  = 3'b111;
                        end
                        RT_SP_OK: begin
                            d.fin   = 1'b1;
                            d.paddr = sp_page;
                            d.perm  = 3'b111;
                        end
                        RT_BADVA, RT_SP_DENY: begin
                            d.fin   = 1'b1;
                            d.fault = 1'b1;
                            d.code  = FLT_ACCVIO;
                        end
                        default: begin
                            d.st      = ST_WALK;
                            d.lvl     = '0;
                            d.rd      = 1'b1;
                            d.rd_addr = tbl_root + (ADDR_W'(idx_top) << ENT_SH);
                        end
                    endcase
                end
            end
            default: begin
                if (mem_rsp_valid) begin
                    if (!at_leaf) begin
                        if (!dir_ok) begin
                            d.st    = ST_IDLE;
                            d.fin   = 1'b1;
                            d.fault = 1'b1;
                            d.code  = dir_code;
                        end else begin
                            d.lvl     = lvl_nxt;
                            d.rd      = 1'b1;
                            d.rd_addr = frame + (ADDR_W'(idx_lv[lvl_nxt]) << ENT_SH);
                        end
                    end else begin
                        d.st    = ST_IDLE;
                        d.fin   = 1'b1;
                        d.fault = leaf_fault;
                        d.code  = leaf_code;
                        d.perm  = leaf_perm;
                        d.paddr = leaf_fault ? '0 : frame;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_ready     = (q.st == ST_IDLE);
    assign mem_req_valid = q.rd;
    assign mem_req_addr  = q.rd_addr;
    assign done          = q.fin;
    assign done_fault    = q.fault;
    assign done_code     = q.code;
    assign done_paddr    = q.paddr;
    assign done_perm     = q.perm;
    assign done_vaddr    = q.va;
    assign done_acc      = (q.acc == ACC_FETCH) ? {ADDR_W{1'b1}}
                                                : ADDR_W'(q.acc == ACC_STORE);

endmodule

// File: rtl/ptw_chk.sv
module ptw_chk #(
    parameter int unsigned ADDR_W  = 64,
    parameter int unsigned VA_BITS = 43
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_vaddr,
    input logic [1:0]        req_mode,
    input logic              req_phys,
    input logic              mem_req_valid,
    input logic              done,
    input logic              done_fault,
    input logic [2:0]        done_code,
    input logic [2:0]        done_perm,
    input logic [ADDR_W-1:0] done_acc
);
    localparam int unsigned HI_W = ADDR_W - VA_BITS;

    logic fire, sign_ok, window, busy_q;
    assign fire    = req_valid && req_ready;
    assign sign_ok = (req_vaddr[ADDR_W-1:VA_BITS] == {HI_W{req_vaddr[ADDR_W-1]}});
    assign window  = req_vaddr[ADDR_W-1] && (req_vaddr[VA_BITS-1 -: 2] == 2'b10);

    always_ff @(posedge clk) begin
        if (!rst_n)    busy_q <= 1'b0;
        else if (fire) busy_q <= 1'b1;
        else if (done) busy_q <= 1'b0;
    end

    a_r1_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        fire && req_phys |=> done && !done_fault && done_perm == 3'b111 && !mem_req_valid);

    a_r2_bad_sign: assert property (@(posedge clk) disable iff (!rst_n)
        fire && !req_phys && !sign_ok |=> done && done_fault && done_code == 3'd1 && !mem_req_valid);

    a_r4_window_deny: assert property (@(posedge clk) disable iff (!rst_n)
        fire && !req_phys && sign_ok && window && req_mode != 2'd0
        |=> done && done_fault && done_code == 3'd1);

    a_r3_window_grant: assert property (@(posedge clk) disable iff (!rst_n)
        fire && !req_phys && sign_ok && window && req_mode == 2'd0
        |=> done && !done_fault && done_perm == 3'b111);

    a_r12_idle_when_reading: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);

    a_r12_done_matches_request: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy_q);

    a_r10_code_range: assert property (@(posedge clk) disable iff (!rst_n)
        done && done_fault |-> done_code <= 3'd4);

    a_r9_granted_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        done && !done_fault |-> done_perm != 3'b000);

    a_r11_acc_word: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (done_acc == '0 || done_acc == ADDR_W'(1) || done_acc == {ADDR_W{1'b1}}));

endmodule

bind xlat_walker ptw_chk #(.ADDR_W(ADDR_W), .VA_BITS(VA_BITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_mode(req_mode), .req_phys(req_phys),
    .mem_req_valid(mem_req_valid), .done(done), .done_fault(done_fault),
    .done_code(done_code), .done_perm(done_perm), .done_acc(done_acc)
);

// File: tb/tb_xlat_walker.sv
module tb_xlat_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_vaddr = '0;
    logic [1:0]  req_acc = '0;
    logic [1:0]  req_mode = '0;
    logic        req_phys = 1'b0;
    logic [63:0] tbl_root;
    logic        mem_req_valid;
    logic [63:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        done, done_fault;
    logic [2:0]  done_code, done_perm;
    logic [63:0] done_paddr, done_vaddr, done_acc;

    localparam logic [63:0] ROOT = 64'h0008_0000;
    assign tbl_root = ROOT;

    always #5 clk = ~clk;

    xlat_walker dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_acc(req_acc), .req_mode(req_mode), .req_phys(req_phys),
        .tbl_root(tbl_root), .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .done(done), .done_fault(done_fault), .done_code(done_code),
        .done_paddr(done_paddr), .done_perm(done_perm), .done_vaddr(done_vaddr),
        .done_acc(done_acc)
    );

    typedef struct {
        string       tag;
        logic        fault;
        logic [2:0]  code;
        logic [63:0] paddr;
        logic [2:0]  perm;
        logic [63:0] va;
        logic [63:0] acc;
        int          nrd;
        logic [63:0] ad0, ad1, ad2;
    } exp_t;

    exp_t        expq[$];
    logic [63:0] rdq[$];
    logic [63:0] mem [logic [63:0]];
    int checks = 0, fails = 0, issued = 0, seen = 0, cyc = 0;

    task automatic chk(input string tag, input logic ok, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] rdm(input logic [63:0] a);
        return mem.exists(a) ? mem[a] : 64'h0;
    endfunction

    // independent model of the requirements
    function automatic exp_t model(input string tag, input logic [63:0] va,
                                   input logic [1:0] acc, input logic [1:0] mode, input logic phys);
        exp_t e;
        logic [63:0] pt, pte, a;
        logic [2:0] need, gr, kp;
        e.tag = tag; e.fault = 0; e.code = 0; e.paddr = 0; e.perm = 0; e.va = va;
        e.acc = (acc == 2) ? '1 : ((acc == 1) ? 64'd1 : 64'd0);
        e.nrd = 0; e.ad0 = 0; e.ad1 = 0; e.ad2 = 0;
        if (phys) begin
            e.paddr = va & ~64'h1FFF; e.perm = 3'b111; return e;
        end
        if (va[63:43] != {21{va[63]}}) begin e.fault = 1; e.code = 1; return e; end
        if (va[63] && va[42:41] == 2'b10) begin
            if (mode != 0) begin e.fault = 1; e.code = 1; return e; end
            e.paddr = ({24'h0, va[39:0]} | ({63'h0, va[40]} << 43)) & ~64'h1FFF;
            e.perm = 3'b111; return e;
        end
        pt = ROOT;
        for (int l = 0; l < 3; l++) begin
            a = pt + ({54'h0, va[13 + 10*(2-l) +: 10]} << 3);
            if (l == 0) e.ad0 = a; else if (l == 1) e.ad1 = a; else e.ad2 = a;
            e.nrd++;
            pte = rdm(a);
            if (l < 2) begin
                if (!pte[0]) begin e.code = 0; e.fault = 1; return e; end
                if (!pte[8]) begin e.code = 1; e.fault = 1; return e; end
                pt = {32'h0, pte[63:32]} << 13;
            end else begin
                if (!pte[0]) begin e.code = 0; e.fault = 1; return e; end
                need = (acc == 1) ? 3'b010 : ((acc == 2) ? 3'b100 : 3'b001);
                gr = {pte[8+mode], pte[12+mode], pte[8+mode]};
                if ((gr & need) == 0) begin e.code = 1; e.fault = 1; return e; end
                kp = gr & ~pte[3:1];
                if ((kp & need) == 0) begin
                    e.fault = 1;
                    e.code = need[2] ? 3'd4 : (need[1] ? 3'd3 : 3'd2);
                    return e;
                end
                e.perm = kp;
                e.paddr = {32'h0, pte[63:32]} << 13;
            end
        end
        return e;
    endfunction

    function automatic logic [63:0] mkva(input logic [9:0] i1, input logic [9:0] i2,
                                         input logic [9:0] i3, input logic [12:0] off);
        logic [63:0] v;
        v = {21'h0, i1, i2, i3, off};
        if (i1[9]) v[63:43] = '1;
        return v;
    endfunction

    // install one mapping; table pages derived from the first index
    task automatic setup(input logic [63:0] va, input logic [15:0] f1,
                         input logic [15:0] f2, input logic [31:0] pfn, input logic [15:0] f3);
        logic [63:0] l2b, l3b;
        logic [31:0] p2, p3;
        p2 = 32'h100 + {22'h0, va[42:33]};
        p3 = 32'h800 + {22'h0, va[42:33]};
        l2b = {32'h0, p2} << 13;
        l3b = {32'h0, p3} << 13;
        mem[ROOT + ({54'h0, va[42:33]} << 3)] = {p2, 16'h0, f1};
        mem[l2b  + ({54'h0, va[32:23]} << 3)] = {p3, 16'h0, f2};
        mem[l3b  + ({54'h0, va[22:13]} << 3)] = {pfn, 16'h0, f3};
    endtask

    task automatic issue(input string tag, input logic [63:0] va, input logic [1:0] acc,
                         input logic [1:0] mode, input logic phys);
        expq.push_back(model(tag, va, acc, mode, phys));
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_acc = acc; req_mode = mode; req_phys = phys;
        issued++;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // memory model: two-cycle read latency
    initial begin
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (rst_n && mem_req_valid) begin
                logic [63:0] a;
                a = mem_req_addr;
                rdq.push_back(a);
                @(negedge clk);
                @(negedge clk);
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = rdm(a);
            end
        end
    end

    // monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && done) begin
                seen++;
                if (expq.size() == 0) begin
                    chk("R12 unexpected result", 1'b0, 64'd1, 64'd0);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    chk({e.tag, " fault"}, done_fault === e.fault, {63'h0, done_fault}, {63'h0, e.fault});
                    if (e.fault)
                        chk({e.tag, " code"}, done_code === e.code, {61'h0, done_code}, {61'h0, e.code});
                    else begin
                        chk({e.tag, " paddr"}, done_paddr === e.paddr, done_paddr, e.paddr);
                        chk({e.tag, " perm"}, done_perm === e.perm, {61'h0, done_perm}, {61'h0, e.perm});
                    end
                    chk({e.tag, " R11 vaddr"}, done_vaddr === e.va, done_vaddr, e.va);
                    chk({e.tag, " R11 acc"}, done_acc === e.acc, done_acc, e.acc);
                    chk({e.tag, " R5 reads"}, rdq.size() == e.nrd, 64'(rdq.size()), 64'(e.nrd));
                    if (rdq.size() == e.nrd) begin
                        if (e.nrd > 0) chk({e.tag, " R5 L1 addr"}, rdq[0] === e.ad0, rdq[0], e.ad0);
                        if (e.nrd > 1) chk({e.tag, " R5 L2 addr"}, rdq[1] === e.ad1, rdq[1], e.ad1);
                        if (e.nrd > 2) chk({e.tag, " R5 L3 addr"}, rdq[2] === e.ad2, rdq[2], e.ad2);
                    end
                end
                rdq.delete();
            end
        end
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000) begin
            chk("watchdog expired", 1'b0, 64'(cyc), 64'd0);
            summary();
        end
    end

    initial begin
        logic [63:0] v;
        // leaf flag words: V=1 NoRd=2 NoWr=4 NoEx=8 KRE=100 ERE=200 URE=800 KWE=1000 UWE=8000
        setup(mkva(10'd1, 10'd3, 10'd5, 13'h10), 16'h0101, 16'h0101, 32'h0005_4321, 16'h1101);
        setup(mkva(10'd2, 10'd7, 10'd9, 13'h0),  16'h0101, 16'h0101, 32'h0000_0777, 16'h0101);
        setup(mkva(10'd3, 10'd1, 10'd2, 13'h0),  16'h0101, 16'h0101, 32'h0001_2000, 16'h8901);
        setup(mkva(10'd5, 10'd2, 10'd2, 13'h0),  16'h0101, 16'h0001, 32'h0000_0123, 16'h1101);
        setup(mkva(10'd6, 10'd2, 10'd2, 13'h0),  16'h0001, 16'h0101, 32'h0000_0123, 16'h1101);
        setup(mkva(10'd7, 10'd4, 10'd8, 13'h0),  16'h0101, 16'h0101, 32'h0000_0321, 16'h1100);
        setup(mkva(10'd8, 10'd1, 10'd1, 13'h0),  16'h0101, 16'h0101, 32'h0000_0888, 16'h1109);
        setup(mkva(10'd9, 10'd1, 10'd1, 13'h0),  16'h0101, 16'h0101, 32'h0000_0999, 16'h1105);
        setup(mkva(10'd10, 10'd1, 10'd1, 13'h0), 16'h0101, 16'h0101, 32'h0000_0AAA, 16'h1103);
        setup(mkva(10'd11, 10'd1, 10'd1, 13'h0), 16'h0101, 16'h0101, 32'h0000_0BBB, 16'h0101);
        setup(mkva(10'd12, 10'd6, 10'd6, 13'h0), 16'h0101, 16'h0101, 32'h0000_0CCC, 16'h0201);
        setup(mkva(10'h305, 10'd9, 10'h3FF, 13'h1FFF), 16'h0101, 16'h0101, 32'hFFFF_FFFF, 16'h1101);

        repeat (3) @(negedge clk);
        chk("R12 reset ready", req_ready === 1'b1, {63'h0, req_ready}, 64'd1);
        chk("R12 reset done low", done === 1'b0, {63'h0, done}, 64'd0);
        chk("R5 reset no read", mem_req_valid === 1'b0, {63'h0, mem_req_valid}, 64'd0);
        rst_n = 1'b1;

        issue("R1 bypass store", 64'h1234_5678_9ABC_DEF0, 2'd1, 2'd3, 1'b1);
        issue("R1 bypass bad-sign addr", 64'h0000_1000_0000_0000, 2'd2, 2'd0, 1'b1);
        issue("R2 high bit set", 64'h0000_1000_0000_0000, 2'd0, 2'd0, 1'b0);
        issue("R2 only bit63", 64'h8000_0000_0000_0000, 2'd1, 2'd0, 1'b0);
        issue("R2 bit43 only", 64'h0000_0800_0000_0000, 2'd0, 2'd0, 1'b0);
        issue("R3 window kernel", 64'hFFFF_FD12_3456_789A, 2'd0, 2'd0, 1'b0);
        issue("R3 window no bit40", 64'hFFFF_FC00_0000_2345, 2'd2, 2'd0, 1'b0);
        issue("R4 window user", 64'hFFFF_FD12_3456_789A, 2'd0, 2'd3, 1'b0);
        issue("R4 window super", 64'hFFFF_FC00_0000_0000, 2'd1, 2'd2, 1'b0);
        issue("R6 walk kernel load", mkva(10'd1, 10'd3, 10'd5, 13'h10), 2'd0, 2'd0, 1'b0);
        issue("R6 walk kernel store", mkva(10'd1, 10'd3, 10'd5, 13'h10), 2'd1, 2'd0, 1'b0);
        issue("R9 user no URE", mkva(10'd2, 10'd7, 10'd9, 13'h0), 2'd0, 2'd3, 1'b0);
        issue("R9 user with URE", mkva(10'd3, 10'd1, 10'd2, 13'h0), 2'd1, 2'd3, 1'b0);
        issue("R9 exec mode ERE", mkva(10'd12, 10'd6, 10'd6, 13'h0), 2'd2, 2'd1, 1'b0);
        issue("R9 store no KWE", mkva(10'd11, 10'd1, 10'd1, 13'h0), 2'd1, 2'd0, 1'b0);
        issue("R7 L1 invalid", mkva(10'd4, 10'd0, 10'd0, 13'h0), 2'd0, 2'd0, 1'b0);
        issue("R7 L2 no read-enable", mkva(10'd5, 10'd2, 10'd2, 13'h0), 2'd0, 2'd0, 1'b0);
        issue("R7 L1 no read-enable", mkva(10'd6, 10'd2, 10'd2, 13'h0), 2'd0, 2'd0, 1'b0);
        issue("R8 leaf invalid", mkva(10'd7, 10'd4, 10'd8, 13'h0), 2'd0, 2'd0, 1'b0);
        issue("R10 fault on exec", mkva(10'd8, 10'd1, 10'd1, 13'h0), 2'd2, 2'd0, 1'b0);
        issue("R10 masked load ok", mkva(10'd8, 10'd1, 10'd1, 13'h0), 2'd0, 2'd0, 1'b0);
        issue("R10 fault on write", mkva(10'd9, 10'd1, 10'd1, 13'h0), 2'd1, 2'd0, 1'b0);
        issue("R10 fault on read", mkva(10'd10, 10'd1, 10'd1, 13'h0), 2'd0, 2'd0, 1'b0);
        issue("R10 store past read mask", mkva(10'd10, 10'd1, 10'd1, 13'h0), 2'd1, 2'd0, 1'b0);
        v = mkva(10'h305, 10'd9, 10'h3FF, 13'h1FFF);
        issue("R5 negative walk", v, 2'd2, 2'd0, 1'b0);
        issue("R11 fetch unmapped", mkva(10'd20, 10'd0, 10'd0, 13'h0), 2'd2, 2'd1, 1'b0);

        while (expq.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        chk("R12 one result per request", seen == issued, 64'(seen), 64'(issued));
        chk("R12 idle at end", req_ready === 1'b1, {63'h0, req_ready}, 64'd1);
        summary();
    end
endmodule